// File: doc/BRIEF.md
# Waveform Hit-Count Rasterizer

The block turns a stream of plot coordinates into an intensity image. Each valid coordinate that falls on the display grid adds one to a per-pixel counter. Pixels that the trace passes through often end up bright and pixels it seldom touches stay dim, so the stored image is a hit-density map rather than a set of single dots.

Two equal memory banks share the work. During a field, one bank collects the hits while the other streams its finished picture out in raster order. As each pixel is streamed it is cleared to zero, so that bank is empty when it next collects hits. A field-start pulse exchanges the roles of the two banks and starts a new read-out from pixel zero. The accumulate path is a two-stage read-modify-write with forwarding, so a hit stream may land on the same pixel every cycle.

Top module: `rast_hitmap`

## Requirements
- R1: Every accepted hit at an in-grid coordinate (x < GRID_W, y < GRID_H) adds exactly one to the count of pixel index y*GRID_W + x.
- R2: Hits always go to the collecting bank and the read-out always comes from the other bank, so hits landing while a read-out runs do not change the values being streamed.
- R3: A field-start pulse exchanges the two banks. The hits taken since the previous pulse (or since reset) are streamed out after this pulse.
- R4: A pixel count stops at 2^CNT_W-1 and never wraps; further hits leave it at that value.
- R5: Each pixel is zeroed as it is streamed, so a bank's next read-out shows only the hits of its next collecting field.
- R6: Hits arriving on consecutive cycles, including hits on the same pixel, are each counted. No increment is lost.
- R7: After a field-start pulse sampled at clock edge E, pix_valid is high from edge E+2 for exactly GRID_W*GRID_H cycles. During that time pix_index runs 0, 1, 2, ... in raster order (row by row, left to right), and pix_value is the count of that pixel.
- R8: A hit with x >= GRID_W or y >= GRID_H is dropped and changes no count.
- R9: After reset pix_valid is low and every count in both banks is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_valid | input | 1 | Qualifies hit_x and hit_y |
| hit_x | input | COORD_W | Horizontal plot coordinate |
| hit_y | input | COORD_W | Vertical plot coordinate |
| field_start | input | 1 | One-cycle pulse: exchange banks and start a read-out |
| pix_valid | output | 1 | A read-out pixel is present |
| pix_value | output | CNT_W | Hit count of the streamed pixel |
| pix_index | output | $clog2(GRID_W*GRID_H) | Raster index of the streamed pixel |

## Verification
The assertions take two things for granted about the inputs. First, field_start is never raised while a hit is being sampled or in the cycle after one, so the two-cycle write pipeline has drained into the old bank before it changes role. Second, field_start is never raised while a read-out is still running, so a bank is fully cleared before it collects again. The stimulus keeps to both rules. The field task first drives two idle cycles, then waits until at least GRID_W*GRID_H+2 cycles have passed since the last pulse. Only after that does it issue the pulse. Hits are free at all other times, including during read-outs.

// File: rtl/rast_pkg.sv
package rast_pkg;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_RUN  = 1'b1
    } scan_state_e;

    localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/rast_bank.sv
module rast_bank #(
    parameter int unsigned DEPTH = 128,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    acc_addr,
    output logic [CNT_W-1:0] acc_rdata,
    input  logic             acc_we,
    input  logic [AW-1:0]    acc_waddr,
    input  logic [CNT_W-1:0] acc_wdata,
    input  logic [AW-1:0]    clr_addr,
    output logic [CNT_W-1:0] clr_rdata,
    input  logic             clr_we
);

    logic [CNT_W-1:0] mem_q [DEPTH];

    assign acc_rdata = mem_q[acc_addr];
    assign clr_rdata = mem_q[clr_addr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            if (acc_we) begin
                mem_q[acc_waddr] <= acc_wdata;
            end
            if (clr_we) begin
                mem_q[clr_addr] <= '0;
            end
        end
    end

endmodule

// File: rtl/rast_accum.sv
module rast_accum #(
    parameter int unsigned GRID_W  = 16,
    parameter int unsigned GRID_H  = 8,
    parameter int unsigned COORD_W = 6,
    parameter int unsigned CNT_W   = 8,
    localparam int unsigned NPIX   = GRID_W * GRID_H,
    localparam int unsigned AW     = $clog2(NPIX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [COORD_W-1:0] in_x,
    input  logic [COORD_W-1:0] in_y,
    input  logic               acc_bank,
    output logic [AW-1:0]      rd_addr,
    output logic               rd_bank,
    input  logic [CNT_W-1:0]   rd_data,
    output logic               wr_en,
    output logic               wr_bank,
    output logic [AW-1:0]      wr_addr,
    output logic [CNT_W-1:0]   wr_data
);

    localparam int unsigned   LW   = 2 * COORD_W + 1;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic             s1_vld;
        logic             s1_bank;
        logic [AW-1:0]    s1_addr;
        logic             s2_vld;
        logic             s2_bank;
        logic [AW-1:0]    s2_addr;
        logic [CNT_W-1:0] s2_cnt;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic             in_grid;
    logic             fwd_hit;
    logic [CNT_W-1:0] old_cnt;

    always_comb begin
        st_d    = st_q;
        in_grid = (in_x < COORD_W'(GRID_W)) && (in_y < COORD_W'(GRID_H));

        // stage 1: capture an in-grid hit with its bank tag
        st_d.s1_vld  = in_valid && in_grid;
        st_d.s1_bank = acc_bank;
        st_d.s1_addr = AW'(LW'(in_y) * LW'(GRID_W) + LW'(in_x));

        // stage 2: read old count, forwarding the write still in flight
        fwd_hit = st_q.s2_vld && (st_q.s2_bank == st_q.s1_bank)
                  && (st_q.s2_addr == st_q.s1_addr);
        old_cnt = fwd_hit ? st_q.s2_cnt : rd_data;

        st_d.s2_vld  = st_q.s1_vld;
        st_d.s2_bank = st_q.s1_bank;
        st_d.s2_addr = st_q.s1_addr;
        st_d.s2_cnt  = (old_cnt == CMAX) ? old_cnt : old_cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_addr = st_q.s1_addr;
    assign rd_bank = st_q.s1_bank;
    assign wr_en   = st_q.s2_vld;
    assign wr_bank = st_q.s2_bank;
    assign wr_addr = st_q.s2_addr;
    assign wr_data = st_q.s2_cnt;

    AST_BACK_TO_BACK_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && wr_addr == $past(wr_addr) && wr_bank == $past(wr_bank)
         && $past(wr_data) != CMAX)
        |-> wr_data == CNT_W'($past(wr_data) + 1'b1)); // R6

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && wr_addr == $past(wr_addr) && wr_bank == $past(wr_bank)
         && $past(wr_data) == CMAX)
        |-> wr_data == CMAX); // R4

endmodule

// File: rtl/rast_scan.sv
module rast_scan
    import rast_pkg::*;
#(
    parameter int unsigned NPIX  = 128,
    parameter int unsigned CNT_W = 8,
    localparam int unsigned AW   = $clog2(NPIX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             field_start,
    input  logic [CNT_W-1:0] rd_data,
    output logic             acc_bank,
    output logic             clr_en,
    output logic [AW-1:0]    clr_addr,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_data,
    output logic [AW-1:0]    out_index
);

    localparam logic [AW-1:0] LAST = AW'(NPIX - 1);

    typedef struct packed {
        logic             bank;
        scan_state_e      state;
        logic [AW-1:0]    addr;
        logic             ov;
        logic [CNT_W-1:0] od;
        logic [AW-1:0]    oi;
    } scan_st_t;

    scan_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.ov = 1'b0;
        if (st_q.state == SCAN_RUN) begin
            st_d.ov = 1'b1;
            st_d.od = rd_data;
            st_d.oi = st_q.addr;
            if (st_q.addr == LAST) begin
                st_d.state = SCAN_IDLE;
            end else begin
                st_d.addr = st_q.addr + 1'b1;
            end
        end
        if (field_start) begin
            st_d.bank  = ~st_q.bank;
            st_d.state = SCAN_RUN;
            st_d.addr  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{bank: 1'b0, state: SCAN_IDLE, addr: '0, ov: 1'b0, od: '0, oi: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_bank  = st_q.bank;
    assign clr_en    = (st_q.state == SCAN_RUN);
    assign clr_addr  = st_q.addr;
    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;
    assign out_index = st_q.oi;

    AST_RASTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_index == AW'($past(out_index) + 1'b1)); // R7

    AST_RASTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_index == '0); // R7

endmodule

// File: rtl/rast_hitmap.sv
module rast_hitmap #(
    parameter int unsigned GRID_W  = 16,
    parameter int unsigned GRID_H  = 8,
    parameter int unsigned COORD_W = 6,
    parameter int unsigned CNT_W   = 8,
    localparam int unsigned NPIX   = GRID_W * GRID_H,
    localparam int unsigned AW     = $clog2(NPIX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hit_valid,
    input  logic [COORD_W-1:0] hit_x,
    input  logic [COORD_W-1:0] hit_y,
    input  logic               field_start,
    output logic               pix_valid,
    output logic [CNT_W-1:0]   pix_value,
    output logic [AW-1:0]      pix_index
);

    import rast_pkg::*;

    logic             acc_bank;
    logic             rd_bank_sel;
    logic [AW-1:0]    acc_rd_addr;
    logic [CNT_W-1:0] acc_rd_data;
    logic             wr_en;
    logic             wr_bank;
    logic [AW-1:0]    wr_addr;
    logic [CNT_W-1:0] wr_data;
    logic             clr_en;
    logic [AW-1:0]    clr_addr;
    logic [CNT_W-1:0] scan_rd_data;
    logic [CNT_W-1:0] bank_acc_rdata [NUM_BANKS];
    logic [CNT_W-1:0] bank_clr_rdata [NUM_BANKS];

    rast_accum #(
        .GRID_W  (GRID_W),
        .GRID_H  (GRID_H),
        .COORD_W (COORD_W),
        .CNT_W   (CNT_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (hit_valid),
        .in_x     (hit_x),
        .in_y     (hit_y),
        .acc_bank (acc_bank),
        .rd_addr  (acc_rd_addr),
        .rd_bank  (rd_bank_sel),
        .rd_data  (acc_rd_data),
        .wr_en    (wr_en),
        .wr_bank  (wr_bank),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    rast_scan #(
        .NPIX  (NPIX),
        .CNT_W (CNT_W)
    ) u_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .field_start (field_start),
        .rd_data     (scan_rd_data),
        .acc_bank    (acc_bank),
        .clr_en      (clr_en),
        .clr_addr    (clr_addr),
        .out_valid   (pix_valid),
        .out_data    (pix_value),
        .out_index   (pix_index)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        rast_bank #(
            .DEPTH (NPIX),
            .CNT_W (CNT_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_addr  (acc_rd_addr),
            .acc_rdata (bank_acc_rdata[b]),
            .acc_we    (wr_en && (wr_bank == 1'(b))),
            .acc_waddr (wr_addr),
            .acc_wdata (wr_data),
            .clr_addr  (clr_addr),
            .clr_rdata (bank_clr_rdata[b]),
            .clr_we    (clr_en && (acc_bank != 1'(b)))
        );
    end

    assign acc_rd_data  = bank_acc_rdata[rd_bank_sel];
    assign scan_rd_data = bank_clr_rdata[~acc_bank];

    AST_QUIET_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> (!hit_valid && !$past(hit_valid))); // R3

    AST_FIELD_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> !clr_en); // R5

    AST_BANK_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && clr_en) |-> (wr_bank == acc_bank)); // R2

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_valid) |-> $past(clr_en)); // R9

endmodule

// File: tb/rast_hitmap_tb.sv
module rast_hitmap_tb;

    localparam int GW   = 16;
    localparam int GH   = 8;
    localparam int CW   = 6;
    localparam int NB   = 8;
    localparam int NPIX = GW * GH;
    localparam int AW   = $clog2(NPIX);
    localparam int CMAX = (1 << NB) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hit_valid = 1'b0;
    logic [CW-1:0] hit_x = '0;
    logic [CW-1:0] hit_y = '0;
    logic          field_start = 1'b0;
    logic          pix_valid;
    logic [NB-1:0] pix_value;
    logic [AW-1:0] pix_index;

    always #2 clk = ~clk;

    rast_hitmap #(.GRID_W(GW), .GRID_H(GH), .COORD_W(CW), .CNT_W(NB)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_valid   (hit_valid),
        .hit_x       (hit_x),
        .hit_y       (hit_y),
        .field_start (field_start),
        .pix_valid   (pix_valid),
        .pix_value   (pix_value),
        .pix_index   (pix_index)
    );

    typedef struct {
        int    idx;
        int    val;
        string tag;
    } exp_t;

    exp_t  sb_q[$];
    int    model[NPIX];
    int    checks = 0;
    int    failures = 0;
    int    since_start = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_tag = "R9";

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
        since_start++;
    endtask

    task automatic hit(input int x, input int y);
        hit_valid = 1'b1;
        hit_x = CW'(x);
        hit_y = CW'(y);
        if (x < GW && y < GH) begin
            if (model[y * GW + x] < CMAX) model[y * GW + x]++;
        end
        tick();
        hit_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic field(input string tag);
        idle(2);
        while (since_start < NPIX + 2) tick();
        for (int i = 0; i < NPIX; i++) begin
            sb_q.push_back('{idx: i, val: model[i], tag: tag});
            model[i] = 0;
        end
        field_start = 1'b1;
        tick();
        field_start = 1'b0;
        since_start = 0;
        check(pix_valid == 1'b0, "R7", "valid one cycle after pulse", int'(pix_valid), 0);
        tick();
        check(pix_valid == 1'b1 && pix_index == '0, "R7", "first pixel two cycles after pulse",
              int'(pix_index), 0);
    endtask

    // monitor: pop expected items as the read-out stream appears
    always @(negedge clk) begin
        if (rst_n && pix_valid) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R7", "unexpected pixel index", int'(pix_index), -1);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(int'(pix_index) == e.idx, e.tag, "pixel index", int'(pix_index), e.idx);
                check(int'(pix_value) == e.val, e.tag, $sformatf("count at pixel %0d", e.idx),
                      int'(pix_value), e.val);
            end
        end
    end

    initial begin
        for (int i = 0; i < NPIX; i++) model[i] = 0;
        idle(3);
        check(pix_valid == 1'b0, "R9", "valid during reset", int'(pix_valid), 0);
        rst_n = 1'b1;
        idle(2);
        check(pix_valid == 1'b0, "R9", "valid after reset", int'(pix_valid), 0);
        since_start = NPIX + 2;

        // R9: both banks start empty
        field("R9");
        field("R9");

        // R1: scattered single and repeated hits
        hit(0, 0); hit(15, 7); hit(3, 2); idle(1); hit(3, 2); idle(2); hit(3, 2);
        hit(8, 4); idle(1); hit(15, 0); hit(0, 7);
        field("R1");

        // R2: hits during the read-out of the R1 field; R6: same pixel every cycle
        for (int i = 0; i < 6; i++) hit(5, 5);
        for (int i = 0; i < 4; i++) begin hit(1, 1); hit(2, 1); end
        hit(9, 3); hit(9, 3); hit(10, 3); hit(9, 3);
        // R8: out-of-grid hits interleaved
        hit(16, 0); hit(0, 8); hit(31, 31); hit(63, 2); hit(4, 6); hit(16, 7);
        field("R6");

        // R4: saturation on one pixel, with neighbours
        for (int i = 0; i < 300; i++) hit(7, 2);
        for (int i = 0; i < 260; i++) begin
            if (i % 2 == 0) hit(6, 2); else hit(7, 2);
        end
        hit(12, 6);
        field("R4");

        // R5: reused bank shows only fresh hits (the R4 bank comes back)
        hit(7, 2); hit(12, 6); hit(0, 0);
        field("R5");
        hit(7, 2);
        field("R5");

        // R3: flush the last two fields
        field("R3");
        idle(NPIX + 6);

        check(sb_q.size() == 0, "R7", "items left unread", sb_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R7", "watchdog expired at cycle", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule